// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Core

This block is a 32-bit processor core that retires one instruction on every rising clock edge. In a single cycle it does the following: it reads the instruction word at the program counter, reads two source registers, and sign-extends the 16-bit immediate. It then runs the ALU, reads or writes the data store, and commits the result. The supported subset is R-type add, subtract, and, or and signed set-less-than, plus load word, store word and branch-if-equal.

Control is decoded in two levels. A main decoder turns the opcode into datapath steering and a 2-bit ALU class. A second decoder turns that class, together with the funct field when needed, into a 3-bit ALU operation. Instruction and data storage are internal word-addressed arrays. A test environment fills them through a load port while reset is held. A debug PC output and a read-only register port expose the architectural state after each instruction.

A branch that is taken lands at the branch's own address plus the shifted offset. It does not land at the following address plus the offset. Every decision about an instruction is fully combinational from the current PC, so the core has no multi-cycle state beyond the PC, the registers and the two arrays.

Top module: `cpu_core`

## Requirements
- R1: While `rst` is high at a rising edge, the PC is loaded with parameter `START_PC` and no register or data word changes. `dbg_pc` shows the PC directly.
- R2: Opcode 0x00 is R-type. The result goes to register field [15:11]. The funct field [5:0] selects the operation: 0x20 is add, 0x22 is subtract (rs minus rt), 0x24 is bitwise and, and 0x25 is bitwise or.
- R3: Register 0 always reads as zero on every read port. A write aimed at it has no effect.
- R4: Opcode 0x23 (load word) writes the data word at byte address rs + sign-extended imm to register field [20:16]. The word index is address bits [MEM_AW+1:2].
- R5: Opcode 0x2B (store word) writes register rt to the data word at rs + sign-extended imm. It writes no register.
- R6: Opcode 0x04 (branch-if-equal) with equal rs and rt sets the PC to the branch's own address plus the sign-extended imm shifted left by 2. This holds for positive, negative and zero offsets.
- R7: Every instruction that does not take a branch, including a branch whose operands differ, advances the PC by 4.
- R8: An opcode other than 0x00, 0x23, 0x2B and 0x04 writes neither a register nor a data word, and the PC advances by 4.
- R9: An R-type word whose funct is not one of the five listed codes writes no register.
- R10: Funct 0x2A (set-less-than) writes 1 when rs is less than rt as signed two's-complement values, and 0 otherwise.
- R11: `dbg_rdata` combinationally shows the register selected by `dbg_raddr`.
- R12: An instruction reads its source registers before its own write-back. For example, load into r8 with base r8, or r9 = r9 + r9, both use the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ld_imem_we | input | 1 | Write `ld_data` into instruction word `ld_addr` |
| ld_dmem_we | input | 1 | Write `ld_data` into data word `ld_addr` |
| ld_addr | input | MEM_AW | Word index for the load port |
| ld_data | input | XLEN | Word written through the load port |
| dbg_raddr | input | 5 | Register number shown on `dbg_rdata` |
| dbg_pc | output | XLEN | Current program counter |
| dbg_rdata | output | XLEN | Value of register `dbg_raddr` |

## Verification
Reading an operand and writing back a result fall in the same cycle. When the destination equals a source, the register file must hand out the old value and take the new one only at the edge. The program provokes this with a load whose base and destination are both r8, and with an add whose sources and destination are all r9. Each result is judged against a value that only the pre-write operand can yield. The bench also checks that a store to a word followed by a faulty-opcode word aimed at the same address leaves the first stored value readable by a later load.

// File: rtl/cpu_pkg.sv
package cpu_pkg;

    localparam logic [5:0] OPC_RTYPE = 6'h00;
    localparam logic [5:0] OPC_LOAD  = 6'h23;
    localparam logic [5:0] OPC_STORE = 6'h2B;
    localparam logic [5:0] OPC_BEQ   = 6'h04;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_SLT = 6'h2A;

    typedef enum logic [1:0] {
        CLS_MEM    = 2'b00,
        CLS_BRANCH = 2'b01,
        CLS_FUNCT  = 2'b10,
        CLS_NONE   = 2'b11
    } alu_class_e;

    typedef enum logic [2:0] {
        OP_AND = 3'b000,
        OP_OR  = 3'b001,
        OP_ADD = 3'b010,
        OP_SUB = 3'b110,
        OP_SLT = 3'b111
    } alu_op_e;

    typedef struct packed {
        logic       dst_from_rd;
        logic       b_from_imm;
        logic       wb_from_mem;
        logic       reg_wr;
        logic       mem_rd;
        logic       mem_wr;
        logic       is_branch;
        alu_class_e alu_class;
    } ctrl_t;

endpackage

// File: rtl/cpu_main_dec.sv
module cpu_main_dec
    import cpu_pkg::*;
(
    input  logic [5:0] opcode,
    output ctrl_t      ctrl
);

    always_comb begin
        ctrl = '{dst_from_rd: 1'b0, b_from_imm: 1'b0, wb_from_mem: 1'b0,
                 reg_wr: 1'b0, mem_rd: 1'b0, mem_wr: 1'b0,
                 is_branch: 1'b0, alu_class: CLS_NONE};
        unique case (opcode)
            OPC_RTYPE: begin
                ctrl.dst_from_rd = 1'b1;
                ctrl.reg_wr      = 1'b1;
                ctrl.alu_class   = CLS_FUNCT;
            end
            OPC_LOAD: begin
                ctrl.b_from_imm  = 1'b1;
                ctrl.wb_from_mem = 1'b1;
                ctrl.reg_wr      = 1'b1;
                ctrl.mem_rd      = 1'b1;
                ctrl.alu_class   = CLS_MEM;
            end
            OPC_STORE: begin
                ctrl.b_from_imm  = 1'b1;
                ctrl.mem_wr      = 1'b1;
                ctrl.alu_class   = CLS_MEM;
            end
            OPC_BEQ: begin
                ctrl.is_branch   = 1'b1;
                ctrl.alu_class   = CLS_BRANCH;
            end
            default: begin
                ctrl.alu_class   = CLS_NONE;
            end
        endcase
    end

endmodule

// File: rtl/cpu_alu_dec.sv
module cpu_alu_dec
    import cpu_pkg::*;
(
    input  alu_class_e alu_class,
    input  logic [5:0] funct,
    output alu_op_e    alu_op,
    output logic       op_valid
);

    always_comb begin
        alu_op   = OP_ADD;
        op_valid = 1'b1;
        unique case (alu_class)
            CLS_MEM:    alu_op = OP_ADD;
            CLS_BRANCH: alu_op = OP_SUB;
            CLS_FUNCT: begin
                unique case (funct)
                    FN_ADD:  alu_op = OP_ADD;
                    FN_SUB:  alu_op = OP_SUB;
                    FN_AND:  alu_op = OP_AND;
                    FN_OR:   alu_op = OP_OR;
                    FN_SLT:  alu_op = OP_SLT;
                    default: op_valid = 1'b0;
                endcase
            end
            default: op_valid = 1'b0;
        endcase
    end

endmodule

// File: rtl/cpu_alu.sv
module cpu_alu
    import cpu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  alu_op_e          op,
    input  logic [XLEN-1:0]  a,
    input  logic [XLEN-1:0]  b,
    output logic [XLEN-1:0]  y,
    output logic             zero
);

    logic [XLEN-1:0] diff;
    logic            lt_signed;

    assign diff      = a - b;
    assign lt_signed = $signed(a) < $signed(b);

    always_comb begin
        unique case (op)
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_ADD:  y = a + b;
            OP_SUB:  y = diff;
            OP_SLT:  y = {{(XLEN-1){1'b0}}, lt_signed};
            default: y = '0;
        endcase
    end

    assign zero = (diff == '0);

endmodule

// File: rtl/cpu_regfile.sv
module cpu_regfile #(
    parameter int XLEN = 32,
    parameter int NREG = 32,
    localparam int RAW = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            we,
    input  logic [RAW-1:0]  waddr,
    input  logic [XLEN-1:0] wdata,
    input  logic [RAW-1:0]  ra_a,
    input  logic [RAW-1:0]  ra_b,
    input  logic [RAW-1:0]  ra_dbg,
    output logic [XLEN-1:0] rd_a,
    output logic [XLEN-1:0] rd_b,
    output logic [XLEN-1:0] rd_dbg
);

    logic [XLEN-1:0] regs_q [NREG];

    always_ff @(posedge clk) begin
        if (we && (waddr != '0)) begin
            regs_q[waddr] <= wdata;
        end
    end

    assign rd_a   = (ra_a   == '0) ? '0 : regs_q[ra_a];
    assign rd_b   = (ra_b   == '0) ? '0 : regs_q[ra_b];
    assign rd_dbg = (ra_dbg == '0) ? '0 : regs_q[ra_dbg];

endmodule

// File: rtl/cpu_core.sv
module cpu_core
    import cpu_pkg::*;
#(
    parameter int              XLEN     = 32,
    parameter int              MEM_AW   = 6,
    parameter logic [XLEN-1:0] START_PC = '0,
    localparam int             MEM_WORDS = 1 << MEM_AW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_imem_we,
    input  logic              ld_dmem_we,
    input  logic [MEM_AW-1:0] ld_addr,
    input  logic [XLEN-1:0]   ld_data,
    input  logic [4:0]        dbg_raddr,
    output logic [XLEN-1:0]   dbg_pc,
    output logic [XLEN-1:0]   dbg_rdata
);

    logic [XLEN-1:0] pc_q;
    logic [31:0]     imem [MEM_WORDS];
    logic [XLEN-1:0] dmem [MEM_WORDS];

    logic [31:0]     instr;
    logic [5:0]      opcode;
    logic [4:0]      rs_f, rt_f, rd_f;
    logic [5:0]      funct;
    logic [15:0]     imm;
    logic [XLEN-1:0] imm_ext;
    logic [XLEN-1:0] rs_val, rt_val;
    logic [XLEN-1:0] alu_b, alu_y;
    logic            alu_zero;
    ctrl_t           ctrl;
    alu_op_e         alu_op;
    logic            op_valid;
    logic [XLEN-1:0] mem_word, wb_data;
    logic [4:0]      rf_waddr;
    logic            rf_we, dm_we, take_br;
    logic [XLEN-1:0] pc_seq, pc_br, pc_next;

    // fetch and field split
    assign instr   = imem[pc_q[MEM_AW+1:2]];
    assign opcode  = instr[31:26];
    assign rs_f    = instr[25:21];
    assign rt_f    = instr[20:16];
    assign rd_f    = instr[15:11];
    assign funct   = instr[5:0];
    assign imm     = instr[15:0];
    assign imm_ext = {{(XLEN-16){imm[15]}}, imm};

    cpu_main_dec u_main_dec (
        .opcode (opcode),
        .ctrl   (ctrl)
    );

    cpu_alu_dec u_alu_dec (
        .alu_class (ctrl.alu_class),
        .funct     (funct),
        .alu_op    (alu_op),
        .op_valid  (op_valid)
    );

    cpu_regfile #(.XLEN(XLEN), .NREG(32)) u_rf (
        .clk    (clk),
        .we     (rf_we),
        .waddr  (rf_waddr),
        .wdata  (wb_data),
        .ra_a   (rs_f),
        .ra_b   (rt_f),
        .ra_dbg (dbg_raddr),
        .rd_a   (rs_val),
        .rd_b   (rt_val),
        .rd_dbg (dbg_rdata)
    );

    assign alu_b = ctrl.b_from_imm ? imm_ext : rt_val;

    cpu_alu #(.XLEN(XLEN)) u_alu (
        .op   (alu_op),
        .a    (rs_val),
        .b    (alu_b),
        .y    (alu_y),
        .zero (alu_zero)
    );

    // data access and write-back
    assign mem_word = ctrl.mem_rd ? dmem[alu_y[MEM_AW+1:2]] : '0;
    assign wb_data  = ctrl.wb_from_mem ? mem_word : alu_y;
    assign rf_waddr = ctrl.dst_from_rd ? rd_f : rt_f;
    assign rf_we    = ctrl.reg_wr && op_valid && !rst;
    assign dm_we    = ctrl.mem_wr && !rst;

    // next PC: a taken branch is relative to its own address
    assign take_br = ctrl.is_branch && alu_zero;
    assign pc_seq  = pc_q + {{(XLEN-3){1'b0}}, 3'd4};
    assign pc_br   = pc_q + {imm_ext[XLEN-3:0], 2'b00};
    assign pc_next = take_br ? pc_br : pc_seq;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= START_PC;
        end else begin
            pc_q <= pc_next;
        end
    end

    always_ff @(posedge clk) begin
        if (ld_imem_we) begin
            imem[ld_addr] <= ld_data[31:0];
        end
    end

    always_ff @(posedge clk) begin
        if (ld_dmem_we) begin
            dmem[ld_addr] <= ld_data;
        end else if (dm_we) begin
            dmem[alu_y[MEM_AW+1:2]] <= rt_val;
        end
    end

    assign dbg_pc = pc_q;

endmodule

// File: rtl/cpu_core_chk.sv
module cpu_core_chk
    import cpu_pkg::*;
#(
    parameter int              XLEN     = 32,
    parameter logic [XLEN-1:0] START_PC = '0
) (
    input logic            clk,
    input logic            rst,
    input logic [XLEN-1:0] pc,
    input logic [5:0]      opcode,
    input logic [XLEN-1:0] rs_val,
    input logic [XLEN-1:0] rt_val,
    input logic [XLEN-1:0] imm_ext,
    input logic            rf_we,
    input logic            dm_we,
    input logic [4:0]      dbg_raddr,
    input logic [XLEN-1:0] dbg_rdata
);

    logic known_op;
    assign known_op = (opcode == OPC_RTYPE) || (opcode == OPC_LOAD) ||
                      (opcode == OPC_STORE) || (opcode == OPC_BEQ);

    // R1: reset loads the start address
    p_reset_pc_r1: assert property (@(posedge clk)
        rst |=> (pc == START_PC));

    // R7: non-branch words step by one word
    p_seq_step_r7: assert property (@(posedge clk) disable iff (rst)
        (opcode != OPC_BEQ) |=> (pc == $past(pc) + XLEN'(4)));

    // R6: taken branch is relative to its own address
    p_beq_target_r6: assert property (@(posedge clk) disable iff (rst)
        (opcode == OPC_BEQ && rs_val == rt_val)
        |=> (pc == $past(pc) + {$past(imm_ext[XLEN-3:0]), 2'b00}));

    // R3: register zero reads zero
    p_zero_reg_r3: assert property (@(posedge clk) disable iff (rst)
        (dbg_raddr == 5'd0) |-> (dbg_rdata == '0));

    // R5: store and branch never write a register
    p_no_reg_wr_r5: assert property (@(posedge clk) disable iff (rst)
        (opcode == OPC_STORE || opcode == OPC_BEQ) |-> !rf_we);

    // R4: load writes a register and not memory
    p_load_wr_r4: assert property (@(posedge clk) disable iff (rst)
        (opcode == OPC_LOAD) |-> (rf_we && !dm_we));

    // R8: unknown opcodes write nothing
    p_unknown_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        !known_op |-> (!rf_we && !dm_we));

endmodule

bind cpu_core cpu_core_chk #(.XLEN(XLEN), .START_PC(START_PC)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .pc        (dbg_pc),
    .opcode    (opcode),
    .rs_val    (rs_val),
    .rt_val    (rt_val),
    .imm_ext   (imm_ext),
    .rf_we     (rf_we),
    .dm_we     (dm_we),
    .dbg_raddr (dbg_raddr),
    .dbg_rdata (dbg_rdata)
);

// File: tb/sim_cpu_core.sv
`timescale 1ns/1ps
module sim_cpu_core;

    localparam int          XLEN   = 32;
    localparam int          MEM_AW = 6;
    localparam logic [31:0] S      = 32'h1001_0000;
    localparam int          NPROG  = 28;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              ld_imem_we = 1'b0;
    logic              ld_dmem_we = 1'b0;
    logic [MEM_AW-1:0] ld_addr = '0;
    logic [XLEN-1:0]   ld_data = '0;
    logic [4:0]        dbg_raddr = '0;
    logic [XLEN-1:0]   dbg_pc;
    logic [XLEN-1:0]   dbg_rdata;

    int  checks = 0;
    int  failures = 0;
    bit  done = 1'b0;

    always #2.5 clk = ~clk;

    cpu_core #(.XLEN(XLEN), .MEM_AW(MEM_AW), .START_PC(S)) u0 (
        .clk        (clk),
        .rst        (rst),
        .ld_imem_we (ld_imem_we),
        .ld_dmem_we (ld_dmem_we),
        .ld_addr    (ld_addr),
        .ld_data    (ld_data),
        .dbg_raddr  (dbg_raddr),
        .dbg_pc     (dbg_pc),
        .dbg_rdata  (dbg_rdata)
    );

    typedef struct {
        logic [31:0] pc;
        logic [4:0]  r;
        logic [31:0] v;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    logic [31:0] prog [NPROG];

    function automatic logic [31:0] rt_w(input int rs, input int rt, input int rd, input logic [5:0] fn);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction

    function automatic logic [31:0] it_w(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
        return {op, 5'(rs), 5'(rt), imm};
    endfunction

    task automatic expect_step(input logic [31:0] pc, input int r, input logic [31:0] v, input string tag);
        exp_t e;
        e.pc = pc; e.r = 5'(r); e.v = v; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic load_word(input bit to_imem, input int idx, input logic [31:0] w);
        @(negedge clk);
        ld_imem_we = to_imem;
        ld_dmem_we = !to_imem;
        ld_addr    = MEM_AW'(idx);
        ld_data    = w;
        @(negedge clk);
        ld_imem_we = 1'b0;
        ld_dmem_we = 1'b0;
    endtask

    // driver: program, data and the expected trace
    initial begin
        prog[0]  = it_w(6'h23, 0, 18, 16'd16);          // r18 = 1000
        prog[1]  = it_w(6'h23, 18, 8, 16'd32);          // r8 = M[1032]
        prog[2]  = it_w(6'h23, 0, 9, 16'd20);           // r9 = 7
        prog[3]  = it_w(6'h23, 0, 10, 16'd24);          // r10 = -5
        prog[4]  = rt_w(9, 10, 11, 6'h20);              // add
        prog[5]  = rt_w(9, 10, 12, 6'h22);              // sub
        prog[6]  = rt_w(8, 9, 13, 6'h24);               // and
        prog[7]  = rt_w(8, 9, 14, 6'h25);               // or
        prog[8]  = rt_w(10, 9, 15, 6'h2A);              // slt true
        prog[9]  = rt_w(9, 10, 16, 6'h2A);              // slt false
        prog[10] = rt_w(9, 9, 0, 6'h20);                // write to r0
        prog[11] = it_w(6'h2B, 0, 12, 16'd40);          // store r12
        prog[12] = it_w(6'h23, 0, 17, 16'd40);          // r17 = stored
        prog[13] = rt_w(9, 9, 11, 6'h3F);               // bad funct
        prog[14] = it_w(6'h3F, 0, 9, 16'd40);           // bad opcode
        prog[15] = it_w(6'h04, 9, 11, 16'd5);           // beq not taken
        prog[16] = it_w(6'h04, 17, 12, 16'd3);          // beq taken +3
        prog[17] = rt_w(9, 9, 11, 6'h20);               // skipped
        prog[18] = rt_w(9, 9, 11, 6'h20);               // skipped
        prog[19] = it_w(6'h23, 0, 20, 16'd40);          // reload
        prog[20] = it_w(6'h23, 8, 8, 16'd0);            // base == dest
        prog[21] = rt_w(9, 9, 9, 6'h20);                // r9 = r9 + r9
        prog[22] = it_w(6'h04, 0, 0, 16'd2);            // to 24
        prog[23] = it_w(6'h04, 0, 0, 16'd4);            // to 27
        prog[24] = it_w(6'h04, 0, 0, 16'hFFFF);         // back to 23
        prog[25] = 32'h0;
        prog[26] = 32'h0;
        prog[27] = it_w(6'h04, 0, 0, 16'd0);            // self loop

        expect_step(S + 4,   18, 32'd1000,      "R4 load base");
        expect_step(S + 8,   8,  32'h11223344,  "R4 load base+32");
        expect_step(S + 12,  9,  32'd7,         "R4 load 7");
        expect_step(S + 16,  10, 32'hFFFFFFFB,  "R4 load -5");
        expect_step(S + 20,  11, 32'd2,         "R2 add");
        expect_step(S + 24,  12, 32'd12,        "R2 sub");
        expect_step(S + 28,  13, 32'd4,         "R2 and");
        expect_step(S + 32,  14, 32'h11223347,  "R2 or");
        expect_step(S + 36,  15, 32'd1,         "R10 slt signed true");
        expect_step(S + 40,  16, 32'd0,         "R10 slt false");
        expect_step(S + 44,  0,  32'd0,         "R3 r0 write ignored");
        expect_step(S + 48,  12, 32'd12,        "R5 store leaves regs");
        expect_step(S + 52,  17, 32'd12,        "R5 store then load");
        expect_step(S + 56,  11, 32'd2,         "R9 bad funct no write");
        expect_step(S + 60,  11, 32'd2,         "R8 bad opcode no reg write");
        expect_step(S + 64,  9,  32'd7,         "R7 beq not taken");
        expect_step(S + 76,  11, 32'd2,         "R6 beq taken own address");
        expect_step(S + 80,  20, 32'd12,        "R8 bad opcode no mem write");
        expect_step(S + 84,  8,  32'hABCD0001,  "R12 load base is dest");
        expect_step(S + 88,  9,  32'd14,        "R12 add in place");
        expect_step(S + 96,  0,  32'd0,         "R6 forward branch");
        expect_step(S + 92,  0,  32'd0,         "R6 negative offset");
        expect_step(S + 108, 0,  32'd0,         "R6 forward from 23");
        expect_step(S + 108, 18, 32'd1000,      "R6 zero offset holds");
        expect_step(S + 108, 8,  32'hABCD0001,  "R11 debug read");

        repeat (2) @(negedge clk);
        for (int i = 0; i < NPROG; i++) load_word(1'b1, i, prog[i]);
        load_word(1'b0, 2,  32'h11223344);
        load_word(1'b0, 4,  32'd1000);
        load_word(1'b0, 5,  32'd7);
        load_word(1'b0, 6,  32'hFFFFFFFB);
        load_word(1'b0, 17, 32'hABCD0001);

        @(negedge clk);
        check("R1 reset pc", dbg_pc, S);
        dbg_raddr = 5'd0;
        #0.5;
        check("R3 r0 reads zero", dbg_rdata, 32'd0);
        rst = 1'b0;
    end

    // monitor: one scoreboard item per retired instruction
    initial begin
        exp_t e;
        @(negedge rst);
        while (sb.size() > 0) begin
            @(negedge clk);
            e = sb.pop_front();
            dbg_raddr = e.r;
            #0.5;
            check({e.tag, " pc"}, dbg_pc, e.pc);
            check({e.tag, " reg"}, dbg_rdata, e.v);
        end
        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                #20000;
                checks++;
                failures++;
                $display("FAIL watchdog actual=%0d expected=%0d", sb.size(), 0);
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule